// File: doc/BRIEF.md
# Immediate Constant Load Datapath

This block sits at the write-back side of an execution stage. It decodes a 32-bit constant-load instruction and drives one write port of a 64-bit register file. In full mode the destination receives a 17-bit immediate, formed from a sign bit and a 16-bit field, either sign-extended or zero-extended to 64 bits. In partial mode the destination's current contents come back through a read port, move up by 16 bits, and take the new 16-bit field in their low bits. One full load followed by partial loads therefore builds a constant of any width with a single opcode: two instructions for 32 bits, four for 64 bits.

A second opcode copies a register through the block unchanged, as a move. The source index sits in the low bits of the immediate field. A small two-state write machine (`ST_IDLE`, `ST_WRITE`) registers the result. It takes transition `T_ISSUE` (to or staying in `ST_WRITE`) on every valid matching instruction and transition `T_DRAIN` (back to `ST_IDLE`) otherwise. The write enable is high exactly in `ST_WRITE`. The result selector names the paths `SEL_NONE`, `SEL_SIGN`, `SEL_ZERO`, `SEL_SHIFT` and `SEL_PASS`.

Top module: `const_load_unit`

## Requirements
- R1: Instruction fields, from most to least significant, are: opcode in bits 31..24, partial flag P in bit 23, sign bit S in bit 22, 16-bit immediate in bits 21..6, destination index in bits 5..0. The constant-load opcode is 8'h3C and the move opcode is 8'h3D.
- R2: A valid constant load with P=0 and `zero_ext`=0 writes the 17-bit value {S, imm} sign-extended to 64 bits.
- R3: A valid constant load with P=0 and `zero_ext`=1 writes {47 zero bits, S, imm}.
- R4: A valid constant load with P=1 writes {old bits 47..0 of the read port, imm}; S and `zero_ext` have no effect.
- R5: A valid move (opcode 8'h3D) reads the register named by instruction bits 11..6 and writes that value unchanged to the destination; P, S, the rest of the immediate and `zero_ext` have no effect.
- R6: For every opcode other than the move opcode, `rd_addr` equals instruction bits 5..0 in the same cycle, with no register in between.
- R7: One clock after a valid constant load or move, `wr_en` is 1 and `wr_addr` carries that instruction's destination index along with the result.
- R8: One clock after a cycle with `instr_valid`=0 or an unmatched opcode, `wr_en` is 0 and `wr_data` and `wr_addr` keep their previous values.
- R9: Synchronous active-high reset sets `wr_en`, `wr_data` and `wr_addr` to zero on the next clock.
- R10: A full load followed by partial loads to the same register, with each write completed before the next read, leaves the concatenation of the immediates in that register (for example, 64'hFEDC_BA98_7654_3210 from four instructions).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies `instr` in this cycle |
| instr | input | 32 | Instruction word |
| zero_ext | input | 1 | Selects zero extension for full loads |
| rd_addr | output | 6 | Register file read-port index |
| rd_data | input | 64 | Register file read-port data for `rd_addr` |
| wr_en | output | 1 | Register file write enable |
| wr_addr | output | 6 | Register file write index |
| wr_data | output | 64 | Register file write data |

## Verification
The assertions assume that `rd_data` already reflects the register selected by `rd_addr` in the same cycle. They also assume that `instr`, `instr_valid` and `zero_ext` hold steady and known across each sampling edge. The block has no forwarding, so a partial load is only meaningful once the previous write to its register has landed. The stimulus therefore drives inputs on the falling edge and serves reads from a combinational model of the register file. It leaves one idle cycle after every instruction, so each feedback read sees the committed value.

// File: rtl/cl_pkg.sv
package cl_pkg;

    // Which source feeds the write-back register
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SIGN,
        SEL_ZERO,
        SEL_SHIFT,
        SEL_PASS
    } cl_sel_e;

    // Write-back sequencing
    typedef enum logic {
        ST_IDLE,
        ST_WRITE
    } cl_state_e;

endpackage

// File: rtl/cl_decode.sv
module cl_decode
    import cl_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int IMM_W = 16,
    parameter int IDX_W = 6,
    parameter logic [OPC_W-1:0] OPC_LOAD = 8'h3C,
    parameter logic [OPC_W-1:0] OPC_MOVE = 8'h3D,
    localparam int INSTR_W = OPC_W + 2 + IMM_W + IDX_W
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               instr_valid,
    input  logic               zero_ext,
    output cl_sel_e            sel,
    output logic [IMM_W-1:0]   imm,
    output logic               sign_bit,
    output logic [IDX_W-1:0]   dest,
    output logic [IDX_W-1:0]   rd_addr
);

    localparam int IMM_LO  = IDX_W;
    localparam int SIGN_AT = IDX_W + IMM_W;
    localparam int PART_AT = SIGN_AT + 1;
    localparam int OPC_LO  = PART_AT + 1;

    logic [OPC_W-1:0] opc;
    logic             partial;

    assign opc      = instr[OPC_LO +: OPC_W];
    assign partial  = instr[PART_AT];
    assign sign_bit = instr[SIGN_AT];
    assign imm      = instr[IMM_LO +: IMM_W];
    assign dest     = instr[IDX_W-1:0];

    // Move reads its source from the low immediate bits; all else reads dest
    assign rd_addr = (opc == OPC_MOVE) ? imm[IDX_W-1:0] : dest;

    always_comb begin
        sel = SEL_NONE;
        if (instr_valid) begin
            if (opc == OPC_LOAD) begin
                if (partial)       sel = SEL_SHIFT;
                else if (zero_ext) sel = SEL_ZERO;
                else               sel = SEL_SIGN;
            end else if (opc == OPC_MOVE) begin
                sel = SEL_PASS;
            end
        end
    end

endmodule

// File: rtl/cl_datapath.sv
module cl_datapath
    import cl_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  cl_sel_e           sel,
    input  logic [IMM_W-1:0]  imm,
    input  logic              sign_bit,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] result
);

    localparam int FILL_W = DATA_W - IMM_W - 1;
    localparam int KEEP_W = DATA_W - IMM_W;

    logic [FILL_W-1:0] fill;
    logic [DATA_W-1:0] imm_word;
    logic [DATA_W-1:0] shift_word;

    // Upper fill bits: copies of the sign bit, or zero
    for (genvar b = 0; b < FILL_W; b++) begin : g_fill
        assign fill[b] = (sel == SEL_SIGN) & sign_bit;
    end

    assign imm_word   = {fill, sign_bit, imm};
    // Fixed-distance feedback: plain rewiring, no shifter
    assign shift_word = {rd_data[KEEP_W-1:0], imm};

    always_comb begin
        unique case (sel)
            SEL_SIGN,
            SEL_ZERO:  result = imm_word;
            SEL_SHIFT: result = shift_word;
            SEL_PASS:  result = rd_data;
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/const_load_unit.sv
module const_load_unit
    import cl_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OPC_W  = 8,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 6,
    parameter logic [OPC_W-1:0] OPC_LOAD = 8'h3C,
    parameter logic [OPC_W-1:0] OPC_MOVE = 8'h3D,
    localparam int INSTR_W = OPC_W + 2 + IMM_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               zero_ext,
    output logic [IDX_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]  wr_data
);

    cl_sel_e           sel;
    logic [IMM_W-1:0]  imm;
    logic              sign_bit;
    logic [IDX_W-1:0]  dest;
    logic [DATA_W-1:0] result;

    cl_state_e         state_q;
    cl_state_e         state_d;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  addr_q;

    cl_decode #(
        .OPC_W    (OPC_W),
        .IMM_W    (IMM_W),
        .IDX_W    (IDX_W),
        .OPC_LOAD (OPC_LOAD),
        .OPC_MOVE (OPC_MOVE)
    ) u_decode (
        .instr       (instr),
        .instr_valid (instr_valid),
        .zero_ext    (zero_ext),
        .sel         (sel),
        .imm         (imm),
        .sign_bit    (sign_bit),
        .dest        (dest),
        .rd_addr     (rd_addr)
    );

    cl_datapath #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_datapath (
        .sel      (sel),
        .imm      (imm),
        .sign_bit (sign_bit),
        .rd_data  (rd_data),
        .result   (result)
    );

    // Next state: T_ISSUE on a matching instruction, T_DRAIN otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = (sel != SEL_NONE) ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = (sel != SEL_NONE) ? ST_WRITE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output registers: load only on issue, hold otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            addr_q <= '0;
        end else if (sel != SEL_NONE) begin
            data_q <= result;
            addr_q <= dest;
        end
    end

    assign wr_en   = (state_q == ST_WRITE);
    assign wr_data = data_q;
    assign wr_addr = addr_q;

endmodule

// File: rtl/const_load_unit_chk.sv
module const_load_unit_chk #(
    parameter int DATA_W = 64,
    parameter int OPC_W  = 8,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 6,
    parameter logic [OPC_W-1:0] OPC_LOAD = 8'h3C,
    parameter logic [OPC_W-1:0] OPC_MOVE = 8'h3D,
    localparam int INSTR_W = OPC_W + 2 + IMM_W + IDX_W
) (
    input logic               clk,
    input logic               rst,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic               zero_ext,
    input logic [IDX_W-1:0]   rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]  wr_data
);

    localparam int SIGN_AT = IDX_W + IMM_W;
    localparam int PART_AT = SIGN_AT + 1;
    localparam int OPC_LO  = PART_AT + 1;
    localparam int KEEP_W  = DATA_W - IMM_W;

    logic [OPC_W-1:0] c_opc;
    logic             c_load;
    logic             c_move;

    assign c_opc  = instr[OPC_LO +: OPC_W];
    assign c_load = instr_valid && (c_opc == OPC_LOAD);
    assign c_move = instr_valid && (c_opc == OPC_MOVE);

    AST_ISSUE_WRITES: assert property (@(posedge clk) disable iff (rst)
        (c_load || c_move) |=> (wr_en && wr_addr == $past(instr[IDX_W-1:0]))); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(c_load || c_move) |=> (!wr_en && $stable(wr_data) && $stable(wr_addr))); // R8

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (c_load && !instr[PART_AT] && !zero_ext) |=>
        (wr_data == {{(KEEP_W-1){$past(instr[SIGN_AT])}}, $past(instr[SIGN_AT:IDX_W])})); // R2

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (c_load && !instr[PART_AT] && zero_ext) |=>
        (wr_data[DATA_W-1:IMM_W+1] == '0 && wr_data[IMM_W:0] == $past(instr[SIGN_AT:IDX_W]))); // R3

    AST_PARTIAL_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (c_load && instr[PART_AT]) |=>
        (wr_data == {$past(rd_data[KEEP_W-1:0]), $past(instr[SIGN_AT-1:IDX_W])})); // R4

    AST_MOVE_COPY: assert property (@(posedge clk) disable iff (rst)
        c_move |=> (wr_data == $past(rd_data))); // R5

    AST_READ_DEST: assert property (@(posedge clk) disable iff (rst)
        (c_opc != OPC_MOVE) |-> (rd_addr == instr[IDX_W-1:0])); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!wr_en && wr_data == '0 && wr_addr == '0)); // R9

endmodule

bind const_load_unit const_load_unit_chk #(
    .DATA_W   (DATA_W),
    .OPC_W    (OPC_W),
    .IMM_W    (IMM_W),
    .IDX_W    (IDX_W),
    .OPC_LOAD (OPC_LOAD),
    .OPC_MOVE (OPC_MOVE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .zero_ext    (zero_ext),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
);

// File: tb/tb_const_load_unit.sv
module tb_const_load_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LOAD = 8'h3C;
    localparam logic [7:0] MOVE = 8'h3D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        zero_ext = 1'b0;
    logic [5:0]  rd_addr;
    logic [63:0] rd_data;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [63:0] wr_data;

    logic [63:0] regs [64];
    logic [63:0] prev_data;
    logic [5:0]  prev_addr;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    const_load_unit dut (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr       (instr),
        .zero_ext    (zero_ext),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    // Model register file: combinational read, write on the clock
    assign rd_data = regs[rd_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++)
                regs[i] <= 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_instr(input logic [7:0] opc, input logic p, input logic s,
                             input logic [15:0] imm, input logic [5:0] dest,
                             input logic zx, input logic vld);
        logic [5:0]  src_idx;
        logic [63:0] src;
        logic [63:0] exp_data;
        logic [5:0]  exp_addr;
        logic        is_write;
        string       tag;
        @(negedge clk);
        instr       = {opc, p, s, imm, dest};
        instr_valid = vld;
        zero_ext    = zx;
        #1;
        src_idx = (opc == MOVE) ? imm[5:0] : dest;
        check(rd_addr == src_idx, (opc == MOVE) ? "R5 rd_addr" : "R6 rd_addr",
              64'(rd_addr), 64'(src_idx));
        src      = regs[src_idx];
        is_write = vld && (opc == LOAD || opc == MOVE);
        if (!is_write)           begin exp_data = prev_data; tag = "R8"; end
        else if (opc == MOVE)    begin exp_data = src; tag = "R5"; end
        else if (p)              begin exp_data = {src[47:0], imm}; tag = "R4"; end
        else if (zx)             begin exp_data = {47'b0, s, imm}; tag = "R3"; end
        else                     begin exp_data = {{47{s}}, s, imm}; tag = "R2"; end
        exp_addr = is_write ? dest : prev_addr;
        @(posedge clk);
        #1;
        check(wr_en == is_write, {tag, " R7 wr_en"}, 64'(wr_en), 64'(is_write));
        check(wr_data == exp_data, {tag, " wr_data"}, wr_data, exp_data);
        check(wr_addr == exp_addr, {tag, " R1 wr_addr"}, 64'(wr_addr), 64'(exp_addr));
        prev_data = exp_data;
        prev_addr = exp_addr;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state
        check(wr_en == 1'b0, "R9 wr_en", 64'(wr_en), 64'd0);
        check(wr_data == '0, "R9 wr_data", wr_data, 64'd0);
        check(wr_addr == '0, "R9 wr_addr", 64'(wr_addr), 64'd0);
        prev_data = '0;
        prev_addr = '0;

        // R2 R3 R4 sweep: immediates, sign, zero-extend and partial combinations
        for (int k = 0; k < 256; k++) begin
            for (int c = 0; c < 8; c++) begin
                run_instr(LOAD, c[0], c[1], 16'(k * 257), 6'(k), c[2], 1'b1);
            end
        end

        // R5: move from every source, with junk in unused fields
        for (int sidx = 0; sidx < 64; sidx++) begin
            run_instr(MOVE, 1'b1, 1'b1, 16'hA5C0 | 16'(sidx), 6'(63 - sidx), 1'b1, 1'b1);
        end

        // R8: every unmatched opcode, then a matching one without valid
        for (int o = 0; o < 256; o++) begin
            if (8'(o) != LOAD && 8'(o) != MOVE)
                run_instr(8'(o), 1'b0, 1'b1, 16'hBEEF, 6'(o), 1'b0, 1'b1);
        end
        run_instr(LOAD, 1'b0, 1'b1, 16'h1234, 6'd7, 1'b0, 1'b0);
        run_instr(MOVE, 1'b0, 1'b0, 16'h0003, 6'd8, 1'b0, 1'b0);

        // R10: 64-bit constant from one full and three partial loads
        run_instr(LOAD, 1'b0, 1'b1, 16'hFEDC, 6'd9, 1'b0, 1'b1);
        run_instr(LOAD, 1'b1, 1'b0, 16'hBA98, 6'd9, 1'b0, 1'b1);
        run_instr(LOAD, 1'b1, 1'b1, 16'h7654, 6'd9, 1'b1, 1'b1);
        run_instr(LOAD, 1'b1, 1'b0, 16'h3210, 6'd9, 1'b0, 1'b1);
        @(negedge clk);
        check(regs[9] == 64'hFEDC_BA98_7654_3210, "R10 64-bit chain",
              regs[9], 64'hFEDC_BA98_7654_3210);

        // R10: 32-bit constant from two instructions
        run_instr(LOAD, 1'b0, 1'b0, 16'h8000, 6'd10, 1'b0, 1'b1);
        run_instr(LOAD, 1'b1, 1'b0, 16'h0001, 6'd10, 1'b0, 1'b1);
        @(negedge clk);
        check(regs[10] == 64'h0000_0000_8000_0001, "R10 32-bit chain",
              regs[10], 64'h0000_0000_8000_0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule